// File: doc/BRIEF.md
# Wait-For-Event Sleep Controller

This block keeps, for each core of a cluster, a one-bit event flag and the sleep state that a wait-for-event request can put the core into. A wait-for-event request completes at once when the flag is set, and clears the flag as it does so. When the flag is clear, the core is marked as sleeping for a wait-for-event reason. It then stays halted until a wake source arrives. The wake sources are a send-event broadcast from any core, a pulse of a shared event stream, and the core's own wake timer.

The event stream watches one selectable bit of the system count. For each stream, software picks the bit, the direction of transition and an enable. When a core goes to sleep while at least one stream is enabled, the core's wake timer is loaded with the earliest count value at which an enabled stream will next fire. The timer then fires once the count reaches that value. This matters when the count jumps past the value without the selected bit showing the transition.

A wake-up is applied in one step. It clears the sleep reason, sets the event flag and reports completion of the pending request. A wake-up that lands in the same cycle as a request which would otherwise sleep is not dropped: that request completes and leaves the flag set.

Top module: `wfe_sleep_ctrl`

## Requirements
- R1: After reset every core runs: `event_flag`, `halted`, `wfe_done` and `tmr_armed` are all 0.
- R2: A request on a running core whose flag is 1, with no wake source in that cycle, gives `wfe_done`=1 in the next cycle, clears the flag and leaves the core running.
- R3: A request on a running core whose flag is 0, with no wake source in that cycle, gives `halted`=1 in the next cycle with `wfe_done`=0. The core stays halted for as long as no wake source is present.
- R4: A wake source in a cycle where the core is halted gives, in the next cycle and all together, `halted`=0, `event_flag`=1 and a one-cycle `wfe_done`=1.
- R5: A wake source in the same cycle as a request that would sleep keeps the core running: `event_flag`=1 and `wfe_done`=1 in the next cycle. The following request then completes at once.
- R6: A wake source while the core runs sets its `event_flag` in the next cycle.
- R7: A `sev_req` pulse from any core is registered once and then presented as a wake source to every core in the following cycle.
- R8: Stream s fires in any cycle where it is enabled and bit `strm_bit[s]` of `count_val` differs from its value in the previous cycle and now equals `strm_rise[s]`. Here 1 means a 0-to-1 transition and 0 means a 1-to-0 transition. No stream fires in the first cycle after reset.
- R9: On entry to sleep with any stream enabled, the core's timer arms. Its target is the minimum, over the enabled streams, of count + (2^b − count mod 2^b) + (2^b if bit b of count already equals the direction value), saturated at the all-ones count. The timer fires while armed and `count_val` ≥ target. It disarms on any wake of its core. With no stream enabled it does not arm.
- R10: `wake_seen` shows, for each core, whether any wake source is present in the current cycle, whatever the core's state.
- R11: A request that arrives while the core is halted is ignored: the core stays halted, `wfe_done` stays 0 and the timer keeps its target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wfe_req | input | NUM_CORES | One-cycle wait-for-event request per core |
| sev_req | input | NUM_CORES | One-cycle send-event request per core |
| count_val | input | CNT_W | System count value |
| strm_en | input | NUM_STREAMS | Enable per event stream |
| strm_bit | input | NUM_STREAMS*SEL_W | Count bit watched by each stream |
| strm_rise | input | NUM_STREAMS | Transition direction per stream (1 = 0-to-1) |
| wfe_done | output | NUM_CORES | Request completed (one cycle) |
| halted | output | NUM_CORES | Core sleeping for a wait-for-event reason |
| event_flag | output | NUM_CORES | Event flag per core |
| wake_seen | output | NUM_CORES | A wake source is present this cycle |
| tmr_armed | output | NUM_CORES | Wake timer armed |
| tmr_target | output | NUM_CORES*CNT_W | Wake timer target count |

## Verification
The bench builds the block with two cores, two streams and an 8-bit count. This makes every count value, every watched bit and both directions cheap to sweep. At that width the armed target is checked for all 4096 combinations of count, bit and direction, and this includes the saturation at the top of the count range. The stream pulse is checked on every step of a full count ramp for each bit and direction. Directed sequences cover the handshake cases: a wake in the same cycle as a request, a count jump that only the timer catches, and a broadcast that wakes a different core.

// File: rtl/wfe_pkg.sv
package wfe_pkg;

    typedef enum logic {
        HR_RUN = 1'b0,
        HR_WFE = 1'b1
    } halt_rsn_e;

    typedef struct packed {
        logic      evt;
        halt_rsn_e rsn;
        logic      done;
    } core_st_t;

endpackage

// File: rtl/wfe_evt_stream.sv
module wfe_evt_stream #(
    parameter int CW    = 16,
    parameter int NS    = 2,
    parameter int SEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CW-1:0]      count,
    input  logic [NS-1:0]      en,
    input  logic [NS*SEL_W-1:0] bit_sel,
    input  logic [NS-1:0]      rise,
    output logic               pulse_o,
    output logic [CW-1:0]      nearest_o,
    output logic               any_en_o
);

    localparam logic [CW+1:0] ONE  = (CW+2)'(1);
    localparam logic [CW+1:0] MAXV = {2'b00, {CW{1'b1}}};

    typedef struct packed {
        logic          vld;
        logic [NS-1:0] lvl;
    } strm_st_t;

    strm_st_t st_d, st_q;

    logic [NS-1:0]         cur;
    logic [NS-1:0]         pls;
    logic [NS-1:0][CW-1:0] nxt;

    for (genvar s = 0; s < NS; s++) begin : g_strm
        logic [SEL_W-1:0] sel;
        assign sel    = bit_sel[s*SEL_W +: SEL_W];
        assign cur[s] = count[sel];

        always_comb begin : calc_next
            logic [CW+1:0] tb;
            logic [CW+1:0] low;
            logic [CW+1:0] dl;
            logic [CW+1:0] sm;
            tb  = ONE << sel;
            low = {2'b00, count} & (tb - ONE);
            dl  = tb - low;
            if (cur[s] == rise[s]) begin
                dl = dl + tb;
            end
            sm = {2'b00, count} + dl;
            nxt[s] = (sm > MAXV) ? {CW{1'b1}} : sm[CW-1:0];
        end

        assign pls[s] = st_q.vld && en[s] && (cur[s] != st_q.lvl[s]) && (cur[s] == rise[s]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b1;
        st_d.lvl = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        nearest_o = {CW{1'b1}};
        for (int s = 0; s < NS; s++) begin
            if (en[s] && (nxt[s] < nearest_o)) begin
                nearest_o = nxt[s];
            end
        end
    end

    assign pulse_o  = |pls;
    assign any_en_o = |en;

    // R9: the next stream time always lies ahead of the count, or saturates
    p_nearest_ahead_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_en_o |-> ((nearest_o > count) || (nearest_o == {CW{1'b1}})))
        else $error("nearest stream time not ahead of count");

endmodule

// File: rtl/wfe_wake_timer.sv
module wfe_wake_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          any_en,
    input  logic [CW-1:0] next_time,
    input  logic [CW-1:0] count,
    input  logic          wake,
    output logic          armed_o,
    output logic [CW-1:0] target_o,
    output logic          fire_o
);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] tgt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    arm_eff;

    always_comb begin
        arm_eff = arm && any_en;
        st_d    = st_q;
        if (arm_eff) begin
            st_d.armed = 1'b1;
            st_d.tgt   = next_time;
        end else if (wake) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o  = st_q.armed;
    assign target_o = st_q.tgt;
    assign fire_o   = st_q.armed && (count >= st_q.tgt);

    // R9: arming loads the computed stream time
    p_arm_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && any_en) |=> (armed_o && (target_o == $past(next_time))))
        else $error("timer did not load target");

    // R9: any wake of the core disarms the timer
    p_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && wake && !arm) |=> !armed_o)
        else $error("timer stayed armed after wake");

endmodule

// File: rtl/wfe_core_ctrl.sv
module wfe_core_ctrl
    import wfe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfe_req,
    input  logic wake,
    output logic evt_o,
    output logic halted_o,
    output logic done_o,
    output logic sleep_o
);

    core_st_t st_d, st_q;
    logic     is_halted;
    logic     accept;
    logic     consume;
    logic     sleep;

    always_comb begin
        is_halted = (st_q.rsn == HR_WFE);
        accept    = wfe_req && !is_halted;
        consume   = accept && st_q.evt;
        sleep     = accept && !st_q.evt && !wake;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (is_halted) begin
            if (wake) begin
                st_d.rsn  = HR_RUN;
                st_d.evt  = 1'b1;
                st_d.done = 1'b1;
            end
        end else begin
            if (sleep) begin
                st_d.rsn = HR_WFE;
            end
            if (consume) begin
                st_d.evt  = 1'b0;
                st_d.done = 1'b1;
            end
            if (accept && wake) begin
                st_d.done = 1'b1;
            end
            if (wake) begin
                st_d.evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{evt: 1'b0, rsn: HR_RUN, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o    = st_q.evt;
    assign halted_o = (st_q.rsn == HR_WFE);
    assign done_o   = st_q.done;
    assign sleep_o  = sleep;

    p_consume_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wfe_req && !halted_o && evt_o && !wake) |=> (done_o && !evt_o && !halted_o))
        else $error("pending event not consumed");

    p_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wfe_req && !halted_o && !evt_o && !wake) |=> (halted_o && !done_o))
        else $error("core did not sleep");

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !wake) |=> (halted_o && !done_o))
        else $error("core left sleep without wake");

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && wake) |=> (!halted_o && evt_o && done_o))
        else $error("wake release not atomic");

    p_same_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wfe_req && !halted_o && wake) |=> (!halted_o && evt_o && done_o))
        else $error("same-cycle wake lost");

    p_run_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted_o && wake) |=> evt_o)
        else $error("wake while running not recorded");

endmodule

// File: rtl/wfe_sleep_ctrl.sv
module wfe_sleep_ctrl
    import wfe_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int CNT_W       = 16,
    parameter int NUM_STREAMS = 2,
    localparam int SEL_W      = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES-1:0]         wfe_req,
    input  logic [NUM_CORES-1:0]         sev_req,
    input  logic [CNT_W-1:0]             count_val,
    input  logic [NUM_STREAMS-1:0]       strm_en,
    input  logic [NUM_STREAMS*SEL_W-1:0] strm_bit,
    input  logic [NUM_STREAMS-1:0]       strm_rise,
    output logic [NUM_CORES-1:0]         wfe_done,
    output logic [NUM_CORES-1:0]         halted,
    output logic [NUM_CORES-1:0]         event_flag,
    output logic [NUM_CORES-1:0]         wake_seen,
    output logic [NUM_CORES-1:0]         tmr_armed,
    output logic [NUM_CORES*CNT_W-1:0]   tmr_target
);

    logic             sev_d, sev_q;
    logic             strm_pulse;
    logic [CNT_W-1:0] strm_next;
    logic             strm_any;

    always_comb begin
        sev_d = |sev_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sev_q <= 1'b0;
        end else begin
            sev_q <= sev_d;
        end
    end

    wfe_evt_stream #(
        .CW    (CNT_W),
        .NS    (NUM_STREAMS),
        .SEL_W (SEL_W)
    ) u_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (count_val),
        .en        (strm_en),
        .bit_sel   (strm_bit),
        .rise      (strm_rise),
        .pulse_o   (strm_pulse),
        .nearest_o (strm_next),
        .any_en_o  (strm_any)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic fire;
        logic sleep;
        logic wake;

        assign wake         = sev_q || strm_pulse || fire;
        assign wake_seen[c] = wake;

        wfe_core_ctrl u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wfe_req  (wfe_req[c]),
            .wake     (wake),
            .evt_o    (event_flag[c]),
            .halted_o (halted[c]),
            .done_o   (wfe_done[c]),
            .sleep_o  (sleep)
        );

        wfe_wake_timer #(
            .CW (CNT_W)
        ) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .arm       (sleep),
            .any_en    (strm_any),
            .next_time (strm_next),
            .count     (count_val),
            .wake      (wake),
            .armed_o   (tmr_armed[c]),
            .target_o  (tmr_target[c*CNT_W +: CNT_W]),
            .fire_o    (fire)
        );

        // R9: a timer is only ever armed on a sleeping core
        p_armed_halted_r9: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_armed[c] |-> halted[c])
            else $error("timer armed on running core");

        // R7: a send-event from any core reaches this core a cycle later
        p_sev_bcast_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|sev_req) |=> wake_seen[c])
            else $error("send-event not broadcast");
    end

endmodule

// File: tb/wfe_sleep_ctrl_tb.sv
module wfe_sleep_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NC  = 2;
    localparam int CW  = 8;
    localparam int NS  = 2;
    localparam int SW  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     wfe_req = '0;
    logic [NC-1:0]     sev_req = '0;
    logic [CW-1:0]     count_val = '0;
    logic [NS-1:0]     strm_en = '0;
    logic [NS*SW-1:0]  strm_bit = '0;
    logic [NS-1:0]     strm_rise = '0;
    logic [NC-1:0]     wfe_done, halted, event_flag, wake_seen, tmr_armed;
    logic [NC*CW-1:0]  tmr_target;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wfe_sleep_ctrl #(
        .NUM_CORES   (NC),
        .CNT_W       (CW),
        .NUM_STREAMS (NS)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfe_req    (wfe_req),
        .sev_req    (sev_req),
        .count_val  (count_val),
        .strm_en    (strm_en),
        .strm_bit   (strm_bit),
        .strm_rise  (strm_rise),
        .wfe_done   (wfe_done),
        .halted     (halted),
        .event_flag (event_flag),
        .wake_seen  (wake_seen),
        .tmr_armed  (tmr_armed),
        .tmr_target (tmr_target)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wfe(input int c);
        wfe_req[c] = 1'b1;
        cyc();
        wfe_req[c] = 1'b0;
    endtask

    function automatic int exp_next(input int cnt, input int b, input int r);
        int tb;
        int d;
        int s;
        tb = 1 << b;
        d  = tb - (cnt % tb);
        if (((cnt >> b) & 1) == r) d = d + tb;
        s = cnt + d;
        if (s > 255) s = 255;
        return s;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 event_flag", int'(event_flag), 0);
        check("R1 halted", int'(halted), 0);
        check("R1 wfe_done", int'(wfe_done), 0);
        check("R1 tmr_armed", int'(tmr_armed), 0);

        // R3 sleep with flag clear, no stream enabled: timer does not arm (R9)
        wfe(0);
        check("R3 halted", int'(halted[0]), 1);
        check("R3 done", int'(wfe_done[0]), 0);
        check("R9 no stream no arm", int'(tmr_armed[0]), 0);
        for (int i = 0; i < 5; i++) begin
            count_val = CW'(i * 37);
            cyc();
        end
        check("R3 stays halted", int'(halted[0]), 1);

        // R11 request while halted ignored
        wfe(0);
        check("R11 halted", int'(halted[0]), 1);
        check("R11 done", int'(wfe_done[0]), 0);

        // R7/R10/R4/R6: send-event from core 1 wakes core 0
        sev_req[1] = 1'b1;
        cyc();
        sev_req[1] = 1'b0;
        #2;
        check("R10 wake_seen halted core", int'(wake_seen[0]), 1);
        check("R7 wake_seen sender", int'(wake_seen[1]), 1);
        cyc();
        check("R4 halted cleared", int'(halted[0]), 0);
        check("R4 event set", int'(event_flag[0]), 1);
        check("R4 done", int'(wfe_done[0]), 1);
        check("R6 running core flag", int'(event_flag[1]), 1);
        cyc();
        check("R4 done one cycle", int'(wfe_done[0]), 0);

        // R2 consume
        wfe(0);
        check("R2 done", int'(wfe_done[0]), 1);
        check("R2 flag cleared", int'(event_flag[0]), 0);
        check("R2 running", int'(halted[0]), 0);

        // R5 same-cycle wake
        sev_req[1] = 1'b1;
        cyc();
        sev_req[1] = 1'b0;
        wfe_req[0] = 1'b1;
        cyc();
        wfe_req[0] = 1'b0;
        check("R5 running", int'(halted[0]), 0);
        check("R5 flag", int'(event_flag[0]), 1);
        check("R5 done", int'(wfe_done[0]), 1);
        wfe(0);
        check("R5 next completes", int'(wfe_done[0]), 1);
        check("R5 next not halted", int'(halted[0]), 0);
        check("R5 flag consumed", int'(event_flag[0]), 0);
        wfe(1);
        check("R2 core1 consumed", int'(event_flag[1]), 0);

        // R9 timer expiry on a count jump without a stream transition
        count_val = 8'h10;
        strm_bit[2:0] = 3'd3;
        strm_rise[0] = 1'b1;
        cyc();
        strm_en[0] = 1'b1;
        wfe(0);
        check("R9 armed", int'(tmr_armed[0]), 1);
        check("R9 target", int'(tmr_target[7:0]), 8'h18);
        count_val = 8'h17;
        cyc();
        check("R9 before target", int'(halted[0]), 1);
        count_val = 8'h20;
        #2;
        check("R9 timer wake", int'(wake_seen[0]), 1);
        check("R8 no stream pulse", int'(wake_seen[1]), 0);
        cyc();
        check("R9 woken", int'(halted[0]), 0);
        check("R9 flag", int'(event_flag[0]), 1);
        check("R9 disarmed", int'(tmr_armed[0]), 0);
        check("R9 other core untouched", int'(event_flag[1]), 0);
        strm_en = '0;
        wfe(0);

        // R9 sweep of target, single stream
        for (int b = 0; b < 8; b++) begin
            for (int r = 0; r < 2; r++) begin
                for (int cnt = 0; cnt < 256; cnt++) begin
                    strm_en = '0;
                    count_val = CW'(cnt);
                    strm_bit[2:0] = SW'(b);
                    strm_rise[0] = r[0];
                    cyc();
                    strm_en[0] = 1'b1;
                    wfe(0);
                    check("R9 sweep armed", int'(tmr_armed[0]), 1);
                    check("R9 sweep target", int'(tmr_target[7:0]), exp_next(cnt, b, r));
                    strm_en = '0;
                    sev_req[1] = 1'b1;
                    cyc();
                    sev_req[1] = 1'b0;
                    cyc();
                    wfe(0);
                end
            end
        end

        // R9 two streams: earliest wins
        for (int k = 0; k < 64; k++) begin
            int cnt;
            int b0;
            int b1;
            int r0;
            int r1;
            int e;
            cnt = (k * 29) % 251;
            b0 = k % 8;
            b1 = (k * 3 + 1) % 8;
            r0 = k % 2;
            r1 = (k / 2) % 2;
            strm_en = '0;
            count_val = CW'(cnt);
            strm_bit = {SW'(b1), SW'(b0)};
            strm_rise = {r1[0], r0[0]};
            cyc();
            strm_en = 2'b11;
            wfe(0);
            e = exp_next(cnt, b0, r0);
            if (exp_next(cnt, b1, r1) < e) e = exp_next(cnt, b1, r1);
            check("R9 two-stream target", int'(tmr_target[7:0]), e);
            strm_en = '0;
            sev_req[1] = 1'b1;
            cyc();
            sev_req[1] = 1'b0;
            cyc();
            wfe(0);
        end

        // R8 stream pulse over full ramps
        for (int b = 0; b < 8; b++) begin
            for (int r = 0; r < 2; r++) begin
                strm_en = '0;
                count_val = '0;
                strm_bit = {SW'(0), SW'(b)};
                strm_rise = {1'b0, r[0]};
                cyc();
                strm_en[0] = 1'b1;
                for (int c = 1; c < 256; c++) begin
                    int nb;
                    int pb;
                    count_val = CW'(c);
                    #2;
                    nb = (c >> b) & 1;
                    pb = ((c - 1) >> b) & 1;
                    check("R8 pulse", int'(wake_seen[0]), ((nb != pb) && (nb == r)) ? 1 : 0);
                    cyc();
                end
            end
        end
        strm_en = '0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule